// File: doc/BRIEF.md
# Four-Way Write-Back Data Cache Controller

This block sits between a processor's load/store unit and a word-wide memory port. It caches 64-byte lines in 16 sets of four ways each, for a 32-bit byte address space. Each line holds a tag, a valid flag, a dirty flag and a 2-bit relative age. A request is taken when `req_valid` and `req_ready` are both high. A hit completes without any memory traffic. A load hit returns its word in the next cycle. A store hit merges its word into the line and marks the line dirty.

On a miss the controller holds `req_ready` low and picks a victim way in the selected set. If the victim is dirty, the controller first writes it back to memory as 16 word beats. It then reads the new line in as 16 word beats. Finally it completes the pending access against the filled line. A store miss allocates the line first and then merges the store. Every memory beat is a request held on the port until the memory acknowledges it.

Top module: `wbc_cache`

## Requirements
- R1: A word address is decoded as tag = bits 31..10, set = bits 9..6, word-in-line = bits 5..2. Consecutive 64-byte lines therefore fall into consecutive sets, and lines in different sets never evict each other.
- R2: An access hits only when a way of the addressed set is valid and holds the address tag. At most one way of a set hits, and a hit causes no memory request.
- R3: After reset the controller is idle, with `req_ready` high and `mem_req` and `resp_valid` low. All lines are invalid, so the first access to any line misses.
- R4: A load hit is taken in the cycle `req_ready` is high. `resp_valid` pulses in the following cycle, with the addressed word on `resp_rdata`.
- R5: A store hit writes its word into the line and marks the line dirty, with no memory traffic. A later load of that word returns the stored value.
- R6: On a miss `req_ready` stays low. The new line is read as 16 beats in ascending word order, starting at the line base. `resp_valid` then pulses, carrying the word for a load.
- R7: If the victim is dirty, its 16 words are written to the victim's own line address, in ascending order, before the first fill beat. Memory then holds the latest stored values.
- R8: If the victim is clean or invalid, it is replaced with no write beat at all.
- R9: The victim is the lowest-numbered invalid way of the set. If all four ways are valid, the victim is the least recently used way. Every hit and every completed miss makes the way it touches the most recent.
- R10: A store that misses fills the line first, then merges the store data and leaves the line dirty.
- R11: A memory beat holds `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` steady until a cycle with `mem_ack` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Byte address (word aligned) |
| req_wdata | input | 32 | Store data |
| resp_valid | output | 1 | Access completed (one-cycle pulse) |
| resp_rdata | output | 32 | Load data, valid with resp_valid for loads |
| mem_req | output | 1 | Memory beat requested |
| mem_we | output | 1 | 1 = write-back beat, 0 = fill beat |
| mem_addr | output | 32 | Word address of the beat |
| mem_wdata | output | 32 | Write-back data |
| mem_ack | input | 1 | Memory completes the beat this cycle |
| mem_rdata | input | 32 | Fill data, valid with mem_ack |

## Verification
Random loads and stores use a handful of tags over a few sets, so they separate hits from misses and clean evictions from dirty ones. They also exercise the LRU order under pressure from more tags than ways. The memory acknowledges after random delays, which checks that beats are held on the port and counted in order. Directed sequences cover the cold miss after reset, and lines in consecutive sets that must not conflict. They also cover a fixed four-way fill where one line is touched before a fifth tag arrives, so the chosen victim is known, and a store miss that must allocate, merge and later write back.

// File: rtl/wbc_pkg.sv
package wbc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_EVICT  = 2'd1,
    ST_FILL   = 2'd2,
    ST_FINISH = 2'd3
  } wbc_state_e;

endpackage

// File: rtl/wbc_age_update.sv
module wbc_age_update #(
  parameter int WAYS  = 4,
  parameter int WAY_W = 2
) (
  input  logic [WAYS-1:0][WAY_W-1:0] ages_in,
  input  logic [WAY_W-1:0]           way,
  output logic [WAYS-1:0][WAY_W-1:0] ages_out
);

  logic [WAY_W-1:0] ref_age;
  assign ref_age = ages_in[way];

  // The touched way becomes youngest; only ways younger than it grow one step older.
  for (genvar g = 0; g < WAYS; g++) begin : g_age
    always_comb begin
      if (way == WAY_W'(g)) begin
        ages_out[g] = '0;
      end else if (ages_in[g] < ref_age) begin
        ages_out[g] = ages_in[g] + 1'b1;
      end else begin
        ages_out[g] = ages_in[g];
      end
    end
  end

endmodule

// File: rtl/wbc_tag_dir.sv
module wbc_tag_dir #(
  parameter int WAYS  = 4,
  parameter int SETS  = 16,
  parameter int TAG_W = 22,
  parameter int WAY_W = 2,
  parameter int SET_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] set_idx,
  input  logic [TAG_W-1:0] tag_in,
  input  logic [WAY_W-1:0] sel_way,
  input  logic             touch,
  input  logic             fill,
  input  logic             mark_dirty,
  output logic [WAYS-1:0]  hit_vec,
  output logic             hit,
  output logic [WAY_W-1:0] hit_way,
  output logic [WAY_W-1:0] vict_way,
  output logic             vict_dirty,
  output logic [TAG_W-1:0] vict_tag
);

  logic [TAG_W-1:0]            tag_q   [SETS][WAYS];
  logic [WAYS-1:0]             valid_q [SETS];
  logic [WAYS-1:0]             dirty_q [SETS];
  logic [WAYS-1:0][WAY_W-1:0]  age_q   [SETS];

  logic [WAYS-1:0]             cur_valid, cur_dirty;
  logic [WAYS-1:0][WAY_W-1:0]  cur_age, touched_age;
  logic [WAYS-1:0]             valid_nxt, dirty_nxt, way_sel;
  logic [WAYS-1:0][WAY_W-1:0]  age_nxt;
  logic                        row_en;

  assign cur_valid = valid_q[set_idx];
  assign cur_dirty = dirty_q[set_idx];
  assign cur_age   = age_q[set_idx];

  // Lookup
  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    assign hit_vec[g] = cur_valid[g] && (tag_q[set_idx][g] == tag_in);
    assign way_sel[g] = (sel_way == WAY_W'(g));
  end
  assign hit = |hit_vec;

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_vec[w]) hit_way = WAY_W'(w);
    end
  end

  // Victim: lowest free way first, else the oldest way
  always_comb begin
    logic found;
    found    = 1'b0;
    vict_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!cur_valid[w] && !found) begin
        vict_way = WAY_W'(w);
        found    = 1'b1;
      end
    end
    if (!found) begin
      for (int w = 0; w < WAYS; w++) begin
        if (cur_age[w] == WAY_W'(WAYS-1)) vict_way = WAY_W'(w);
      end
    end
  end

  assign vict_dirty = cur_valid[vict_way] && cur_dirty[vict_way];
  assign vict_tag   = tag_q[set_idx][vict_way];

  wbc_age_update #(.WAYS(WAYS), .WAY_W(WAY_W)) u_age (
    .ages_in  (cur_age),
    .way      (sel_way),
    .ages_out (touched_age)
  );

  // Next-state of the addressed row
  always_comb begin
    valid_nxt = cur_valid | (fill ? way_sel : '0);
    dirty_nxt = cur_dirty;
    if (fill)       dirty_nxt = dirty_nxt & ~way_sel;
    if (mark_dirty) dirty_nxt = dirty_nxt | way_sel;
    age_nxt   = touch ? touched_age : cur_age;
  end

  assign row_en = touch | fill | mark_dirty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) age_q[s][w] <= WAY_W'(w);
      end
    end else if (row_en) begin
      valid_q[set_idx] <= valid_nxt;
      dirty_q[set_idx] <= dirty_nxt;
      age_q[set_idx]   <= age_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (fill) tag_q[set_idx][sel_way] <= tag_in;
  end

endmodule

// File: rtl/wbc_data_ram.sv
module wbc_data_ram #(
  parameter int DATA_W = 32,
  parameter int WAY_W  = 2,
  parameter int SET_W  = 4,
  parameter int WORD_W = 4
) (
  input  logic              clk,
  input  logic [SET_W-1:0]  set_idx,
  input  logic              wr_en,
  input  logic [WAY_W-1:0]  wr_way,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [WAY_W-1:0]  rd_way,
  input  logic [WORD_W-1:0] rd_word,
  output logic [DATA_W-1:0] rd_data
);

  localparam int IDX_W = WAY_W + SET_W + WORD_W;
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [IDX_W-1:0]  wr_idx, rd_idx;

  assign wr_idx  = {wr_way, set_idx, wr_word};
  assign rd_idx  = {rd_way, set_idx, rd_word};
  assign rd_data = mem_q[rd_idx];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_idx] <= wr_data;
  end

endmodule

// File: rtl/wbc_cache.sv
module wbc_cache
  import wbc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int WAYS       = 4,
  parameter int SETS       = 16,
  parameter int LINE_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);

  localparam int BYTE_W = $clog2(DATA_W / 8);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int WORD_W = OFF_W - BYTE_W;
  localparam int SET_W  = $clog2(SETS);
  localparam int WAY_W  = $clog2(WAYS);
  localparam int TAG_W  = ADDR_W - SET_W - OFF_W;
  localparam logic [WORD_W-1:0] LAST_BEAT = '1;

  // Reset: asserted at once, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  // Address fields
  logic [TAG_W-1:0]  req_tag;
  logic [SET_W-1:0]  req_set;
  logic [WORD_W-1:0] req_word;
  logic              unused_lsb;
  assign req_tag    = req_addr[ADDR_W-1 -: TAG_W];
  assign req_set    = req_addr[OFF_W +: SET_W];
  assign req_word   = req_addr[BYTE_W +: WORD_W];
  assign unused_lsb = ^req_addr[BYTE_W-1:0];

  // State
  wbc_state_e        st_q, st_d;
  logic [WORD_W-1:0] beat_q, beat_d;
  logic              resp_valid_q, resp_valid_d;
  logic [DATA_W-1:0] resp_rdata_q, resp_rdata_d;
  logic              lat_write_q;
  logic [TAG_W-1:0]  lat_tag_q, old_tag_q;
  logic [SET_W-1:0]  lat_set_q;
  logic [WORD_W-1:0] lat_word_q;
  logic [DATA_W-1:0] lat_wdata_q;
  logic [WAY_W-1:0]  vway_q;

  // Directory and data array hookup
  logic              idle, accept, hit_acc, lat_en;
  logic [SET_W-1:0]  cur_set;
  logic [TAG_W-1:0]  cur_tag;
  logic [WAYS-1:0]   hit_vec;
  logic              hit, vict_dirty;
  logic [WAY_W-1:0]  hit_way, vict_way, sel_way;
  logic [TAG_W-1:0]  vict_tag;
  logic              touch, fill, mark_dirty;
  logic              ram_we;
  logic [WAY_W-1:0]  ram_wr_way;
  logic [WORD_W-1:0] ram_wr_word, ram_rd_word;
  logic [DATA_W-1:0] ram_wr_data, ram_rd_data;

  assign idle    = (st_q == ST_IDLE);
  assign accept  = idle && req_valid;
  assign hit_acc = accept && hit;
  assign lat_en  = accept && !hit;
  assign cur_set = idle ? req_set : lat_set_q;
  assign cur_tag = idle ? req_tag : lat_tag_q;
  assign sel_way = idle ? hit_way : vway_q;

  wbc_tag_dir #(
    .WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W), .WAY_W(WAY_W), .SET_W(SET_W)
  ) u_dir (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .set_idx    (cur_set),
    .tag_in     (cur_tag),
    .sel_way    (sel_way),
    .touch      (touch),
    .fill       (fill),
    .mark_dirty (mark_dirty),
    .hit_vec    (hit_vec),
    .hit        (hit),
    .hit_way    (hit_way),
    .vict_way   (vict_way),
    .vict_dirty (vict_dirty),
    .vict_tag   (vict_tag)
  );

  wbc_data_ram #(
    .DATA_W(DATA_W), .WAY_W(WAY_W), .SET_W(SET_W), .WORD_W(WORD_W)
  ) u_ram (
    .clk     (clk),
    .set_idx (cur_set),
    .wr_en   (ram_we),
    .wr_way  (ram_wr_way),
    .wr_word (ram_wr_word),
    .wr_data (ram_wr_data),
    .rd_way  (sel_way),
    .rd_word (ram_rd_word),
    .rd_data (ram_rd_data)
  );

  // Datapath control
  always_comb begin
    touch       = 1'b0;
    fill        = 1'b0;
    mark_dirty  = 1'b0;
    ram_we      = 1'b0;
    ram_wr_way  = vway_q;
    ram_wr_word = lat_word_q;
    ram_wr_data = lat_wdata_q;
    ram_rd_word = lat_word_q;
    unique case (st_q)
      ST_IDLE: begin
        touch       = hit_acc;
        mark_dirty  = hit_acc && req_write;
        ram_we      = hit_acc && req_write;
        ram_wr_way  = hit_way;
        ram_wr_word = req_word;
        ram_wr_data = req_wdata;
        ram_rd_word = req_word;
      end
      ST_EVICT: begin
        ram_rd_word = beat_q;
      end
      ST_FILL: begin
        ram_we      = mem_ack;
        ram_wr_word = beat_q;
        ram_wr_data = mem_rdata;
        fill        = mem_ack && (beat_q == LAST_BEAT);
      end
      ST_FINISH: begin
        touch      = 1'b1;
        mark_dirty = lat_write_q;
        ram_we     = lat_write_q;
      end
      default: ;
    endcase
  end

  // Next state
  always_comb begin
    st_d         = st_q;
    beat_d       = beat_q;
    resp_valid_d = hit_acc || (st_q == ST_FINISH);
    resp_rdata_d = resp_valid_d ? ram_rd_data : resp_rdata_q;
    unique case (st_q)
      ST_IDLE: begin
        if (lat_en) begin
          beat_d = '0;
          st_d   = vict_dirty ? ST_EVICT : ST_FILL;
        end
      end
      ST_EVICT: begin
        if (mem_ack) begin
          beat_d = beat_q + 1'b1;
          if (beat_q == LAST_BEAT) st_d = ST_FILL;
        end
      end
      ST_FILL: begin
        if (mem_ack) begin
          beat_d = beat_q + 1'b1;
          if (beat_q == LAST_BEAT) st_d = ST_FINISH;
        end
      end
      ST_FINISH: st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      st_q         <= ST_IDLE;
      beat_q       <= '0;
      resp_valid_q <= 1'b0;
      resp_rdata_q <= '0;
    end else begin
      st_q         <= st_d;
      beat_q       <= beat_d;
      resp_valid_q <= resp_valid_d;
      resp_rdata_q <= resp_rdata_d;
    end
  end

  // Miss context, loaded only when a miss is taken
  always_ff @(posedge clk) begin
    if (lat_en) begin
      lat_write_q <= req_write;
      lat_tag_q   <= req_tag;
      lat_set_q   <= req_set;
      lat_word_q  <= req_word;
      lat_wdata_q <= req_wdata;
      vway_q      <= vict_way;
      old_tag_q   <= vict_tag;
    end
  end

  // Outputs
  assign req_ready  = idle;
  assign resp_valid = resp_valid_q;
  assign resp_rdata = resp_rdata_q;
  assign mem_req    = (st_q == ST_EVICT) || (st_q == ST_FILL);
  assign mem_we     = (st_q == ST_EVICT);
  assign mem_addr   = {(st_q == ST_EVICT) ? old_tag_q : lat_tag_q, lat_set_q, beat_q,
                       {BYTE_W{1'b0}}};
  assign mem_wdata  = ram_rd_data;

endmodule

// File: rtl/wbc_checker.sv
module wbc_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WAYS   = 4,
  parameter int BYTE_W = 2,
  parameter int WORD_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              resp_valid,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              hit,
  input logic [WAYS-1:0]   hit_vec
);

  logic [WORD_W-1:0] beat_w;
  assign beat_w = mem_addr[BYTE_W +: WORD_W];

  AST_ONE_WAY_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)); // R2

  AST_HIT_NEXT_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && hit |=> resp_valid && req_ready); // R4

  AST_MISS_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !hit |=> !req_ready && mem_req); // R6

  AST_BEAT_ASCENDS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && (beat_w != '1) |=>
      mem_req && (beat_w == $past(beat_w) + 1'b1)); // R6

  AST_NO_WB_AFTER_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we |=> !(mem_req && mem_we)); // R7

  AST_WB_THEN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && mem_ack && (beat_w == '1) |=> mem_req && !mem_we); // R7

  AST_BEAT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=>
      mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R11

endmodule

bind wbc_cache wbc_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAYS(WAYS), .BYTE_W(BYTE_W), .WORD_W(WORD_W)
) u_wbc_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .resp_valid (resp_valid),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_ack    (mem_ack),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata),
  .hit        (hit),
  .hit_vec    (hit_vec)
);

// File: tb/test_wbc_cache.sv
module test_wbc_cache;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic        req_ready;
  logic [31:0] req_addr, req_wdata;
  logic        resp_valid;
  logic [31:0] resp_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack;
  logic [31:0] mem_rdata;

  always #2 clk = ~clk;

  wbc_cache i_wbc_cache (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .resp_valid (resp_valid),
    .resp_rdata (resp_rdata),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ack    (mem_ack),
    .mem_rdata  (mem_rdata)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  // Memory contents: architectural view and what the memory really holds
  bit [31:0] arch [bit [31:0]];
  bit [31:0] bmem [bit [31:0]];

  function automatic bit [31:0] seed_word(bit [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h1234_5678;
  endfunction
  function automatic bit [31:0] arch_rd(bit [31:0] a);
    return arch.exists(a) ? arch[a] : seed_word(a);
  endfunction
  function automatic bit [31:0] bmem_rd(bit [31:0] a);
    return bmem.exists(a) ? bmem[a] : seed_word(a);
  endfunction

  // Reference directory built from the requirements
  bit [21:0] m_tag   [16][4];
  bit        m_val   [16][4];
  bit        m_dirty [16][4];
  int        m_age   [16][4];

  function automatic int m_lookup(int s, bit [21:0] t);
    for (int w = 0; w < 4; w++) if (m_val[s][w] && m_tag[s][w] == t) return w;
    return -1;
  endfunction
  function automatic int m_victim(int s);
    for (int w = 0; w < 4; w++) if (!m_val[s][w]) return w;
    for (int w = 0; w < 4; w++) if (m_age[s][w] == 3) return w;
    return 0;
  endfunction
  function automatic void m_touch(int s, int w);
    int a = m_age[s][w];
    for (int k = 0; k < 4; k++) if (k != w && m_age[s][k] < a) m_age[s][k]++;
    m_age[s][w] = 0;
  endfunction

  // Memory responder
  int        n_rd, n_wr;
  bit        order_bad, hold_bad;
  bit [31:0] rd_base, wb_base;
  bit        prev_pend;
  bit [31:0] prev_addr, prev_wd;
  bit        prev_we;

  always @(negedge clk) begin
    if (prev_pend && (!mem_req || mem_addr != prev_addr || mem_we != prev_we ||
                      (mem_we && mem_wdata != prev_wd))) hold_bad = 1'b1;
    if (mem_req && (($urandom % 4) != 0)) begin
      mem_ack = 1'b1;
      if (mem_we) begin
        if (n_rd != 0 || mem_addr != wb_base + 32'(n_wr * 4)) order_bad = 1'b1;
        bmem[mem_addr] = mem_wdata;
        n_wr++;
      end else begin
        if (mem_addr != rd_base + 32'(n_rd * 4)) order_bad = 1'b1;
        mem_rdata = bmem_rd(mem_addr);
        n_rd++;
      end
    end else begin
      mem_ack = 1'b0;
    end
    prev_pend = mem_req && !mem_ack;
    prev_addr = mem_addr;
    prev_we   = mem_we;
    prev_wd   = mem_wdata;
  end

  bit last_hit;

  task automatic access(input bit wr, input bit [31:0] addr, input bit [31:0] wd);
    int        s = int'(addr[9:6]);
    bit [21:0] t = addr[31:10];
    int        w = m_lookup(s, t);
    bit        exp_hit = (w >= 0);
    bit        exp_wb = 1'b0;
    int        lat = 0;
    bit [31:0] exp_rd;
    if (!exp_hit) begin
      w       = m_victim(s);
      exp_wb  = m_val[s][w] && m_dirty[s][w];
      wb_base = {m_tag[s][w], addr[9:6], 6'd0};
      rd_base = {t, addr[9:6], 6'd0};
      m_tag[s][w]   = t;
      m_val[s][w]   = 1'b1;
      m_dirty[s][w] = 1'b0;
    end
    m_touch(s, w);
    exp_rd = arch_rd(addr);
    if (wr) begin
      m_dirty[s][w] = 1'b1;
      arch[addr]    = wd;
    end
    last_hit = exp_hit;
    @(negedge clk);
    n_rd = 0; n_wr = 0; order_bad = 1'b0; hold_bad = 1'b0;
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!resp_valid && lat < 300) begin
      @(negedge clk);
      lat++;
    end
    chk(resp_valid, "R6 response", 32'(lat), 32'd300);
    if (exp_hit) begin
      chk(lat == 0, "R4 hit latency", 32'(lat), 0);
      chk(n_rd == 0 && n_wr == 0, wr ? "R5 hit traffic" : "R2 hit traffic",
          32'(n_rd + n_wr), 0);
    end else begin
      chk(n_rd == 16 && !order_bad, "R6 fill beats", 32'(n_rd), 16);
      chk(!hold_bad, "R11 beat held", 32'(hold_bad), 0);
      if (exp_wb) begin
        bit ok = (n_wr == 16) && !order_bad;
        for (int k = 0; k < 16; k++)
          if (bmem_rd(wb_base + 32'(k * 4)) != arch_rd(wb_base + 32'(k * 4))) ok = 1'b0;
        chk(ok, "R7 dirty write-back", 32'(n_wr), 16);
      end else begin
        chk(n_wr == 0, "R8 clean victim", 32'(n_wr), 0);
      end
    end
    if (!wr) chk(resp_rdata == exp_rd, exp_hit ? "R4 load data" : "R6 load data",
                 resp_rdata, exp_rd);
  endtask

  function automatic bit [31:0] mk(bit [21:0] t, int s, int wd);
    return {t, 4'(s), 4'(wd), 2'b00};
  endfunction

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int s = 0; s < 16; s++)
      for (int w = 0; w < 4; w++) begin
        m_val[s][w] = 1'b0; m_dirty[s][w] = 1'b0; m_age[s][w] = w; m_tag[s][w] = '0;
      end
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    mem_ack = 1'b0; mem_rdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(req_ready && !mem_req && !resp_valid, "R3 reset idle",
        {29'd0, req_ready, mem_req, resp_valid}, 32'd4);

    // Cold miss, then hits and a store hit in the same line
    access(1'b0, 32'h0000_1000, 0);
    chk(!last_hit, "R3 cold miss", 32'(last_hit), 0);
    access(1'b0, 32'h0000_1004, 0);
    access(1'b1, 32'h0000_1008, 32'hCAFE_0001);
    access(1'b0, 32'h0000_1008, 0);
    chk(resp_rdata == 32'hCAFE_0001, "R5 store hit readback", resp_rdata, 32'hCAFE_0001);

    // Consecutive lines land in distinct sets and coexist
    for (int i = 0; i < 6; i++) access(1'b0, 32'h0004_0000 + 32'(i * 64), 0);
    for (int i = 0; i < 6; i++) begin
      access(1'b0, 32'h0004_0000 + 32'(i * 64) + 4, 0);
      chk(last_hit, "R1 consecutive lines", 32'(last_hit), 1);
    end

    // LRU: four tags fill set 5, one is touched, a fifth tag evicts the oldest
    for (int i = 0; i < 4; i++) access(1'b0, mk(22'h010 + 22'(i), 5, 0), 0);
    access(1'b1, mk(22'h011, 5, 3), 32'hBEEF_0011);
    access(1'b0, mk(22'h010, 5, 1), 0);
    access(1'b0, mk(22'h012, 5, 1), 0);
    access(1'b0, mk(22'h013, 5, 1), 0);
    access(1'b0, mk(22'h014, 5, 0), 0);
    access(1'b0, mk(22'h010, 5, 2), 0);
    chk(last_hit, "R9 recent line kept", 32'(last_hit), 1);
    access(1'b0, mk(22'h011, 5, 3), 0);
    chk(!last_hit && resp_rdata == 32'hBEEF_0011, "R9 oldest line evicted",
        resp_rdata, 32'hBEEF_0011);

    // Store miss allocates, merges, later written back
    access(1'b1, mk(22'h2A0, 7, 9), 32'h5107_E000);
    chk(!last_hit, "R10 store miss allocates", 32'(last_hit), 0);
    access(1'b0, mk(22'h2A0, 7, 9), 0);
    chk(last_hit && resp_rdata == 32'h5107_E000, "R10 merged data", resp_rdata,
        32'h5107_E000);
    for (int i = 1; i <= 4; i++) access(1'b0, mk(22'h2A0 + 22'(i), 7, 0), 0);
    chk(bmem_rd(mk(22'h2A0, 7, 9)) == 32'h5107_E000, "R10 line written back",
        bmem_rd(mk(22'h2A0, 7, 9)), 32'h5107_E000);

    // Random mix over a few sets and more tags than ways
    for (int i = 0; i < 700; i++) begin
      bit [21:0] t  = 22'h100 + 22'($urandom % 6);
      int        s  = int'($urandom % 4);
      int        wd = int'($urandom % 16);
      bit        wr = (($urandom % 10) < 4);
      access(wr, mk(t, s, wd), $urandom);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule